// File: doc/BRIEF.md
# Regulator Start-Up and Fault Sequencer

This block is the digital supervisor of a switching regulator. It reads the comparator flags around the power stage: supply above its lockout level, enable above its threshold, the soft-start node below its shutdown level, the soft-start node fully charged, overcurrent and over-temperature. It also counts switching-cycle ticks. From these it decides when the converter may start, when the soft-start capacitor is charged or shorted, and when both gate drivers must be tri-stated.

A start needs a qualified supply and enable. It then charges soft-start and lets the drivers switch. An overcurrent trip latches a hiccup: soft-start is shorted and held for a fixed number of switching cycles, and then a fresh soft-start begins. This repeats for as long as the overload persists. An over-temperature trip stops switching and discharges soft-start, and the block restarts by itself once the hysteretic temperature flag clears. If the soft-start node is pulled below its shutdown level during regulation, the output stops. It resumes when the node rises again.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst_n` is low and at the first sample after its release with all flags low, `por_ok`=0, `ss_charge`=0, `drv_hiz`=1 and `hiccup_on`=0.
- R2: `por_ok` equals `vcc_ok AND en_ok` as sampled at the previous clock edge. When either flag is low, the next edge forces `drv_hiz`=1 and `ss_charge`=0, whatever state the block was in.
- R3: At the edge after both flags are valid, with no over-temperature, soft-start charging begins: `ss_charge`=1 and `drv_hiz`=0.
- R4: Before `ss_top` has been seen in a soft-start, `ss_low` has no effect. After that, `ss_low`=1 shuts the output down (`drv_hiz`=1, `ss_charge` stays 1) at the next edge. Once `ss_low` returns to 0, a new soft-start starts (`drv_hiz`=0) at the following edge.
- R5: `oc_trip`=1 during soft-start or regulation gives `hiccup_on`=1, `ss_charge`=0 and `drv_hiz`=1 at the next edge. `oc_trip` has no effect while the hiccup is running.
- R6: The hiccup lasts exactly HOLD_CYC (default 4096) `cyc_tick` pulses, counted from entry by a 13-bit counter. At the edge that samples the last pulse, soft-start charging restarts (`hiccup_on`=0, `ss_charge`=1, `drv_hiz`=0). A trip that recurs starts the hiccup again.
- R7: `ot_trip`=1 with valid power gives `drv_hiz`=1 and `ss_charge`=0 at the next edge. This overrides overcurrent and hiccup, and `hiccup_on` is 0. At the edge after `ot_trip` clears, soft-start restarts.
- R8: Priority runs from loss of power first, then over-temperature, then overcurrent, then normal sequencing. With power lost, `por_ok` is 0 even while `ot_trip` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| vcc_ok | input | 1 | Bias supply above its lockout level |
| en_ok | input | 1 | Enable above its turn-on threshold |
| ss_low | input | 1 | Soft-start node below its shutdown level |
| ss_top | input | 1 | Soft-start node fully charged |
| oc_trip | input | 1 | Overcurrent comparator trip |
| ot_trip | input | 1 | Over-temperature flag, hysteretic |
| cyc_tick | input | 1 | One pulse per switching cycle |
| por_ok | output | 1 | Power-on-ready, registered |
| ss_charge | output | 1 | 1 charges soft-start, 0 shorts it low |
| drv_hiz | output | 1 | 1 tri-states both gate drivers |
| hiccup_on | output | 1 | Overcurrent hiccup in progress |

## Verification
Every output is registered or decoded from registered state, so each result is due one clock edge after the stimulus that causes it. The one exception is the end of a hiccup, which is due at the edge that samples the HOLD_CYC-th tick. The driver changes flags on a falling edge and queues the expected outputs after the next rising edge. The monitor compares on the falling edge that follows, which is exactly one register stage later. Across the hiccup, ticks are interleaved with idle cycles so that the bench counts ticks rather than clock cycles, and the hold is checked one tick before it ends and again on its final tick.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_CHARGE  = 3'd1,
    ST_RUN     = 3'd2,
    ST_HICCUP  = 3'd3,
    ST_THERMAL = 3'd4,
    ST_SHUT    = 3'd5
  } seq_state_t;
endpackage

// File: rtl/por_qualify.sv
module por_qualify (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_ok,
  input  logic en_ok,
  output logic por_now,
  output logic por_q
);
  logic por_d;

  assign por_now = vcc_ok & en_ok;

  always_comb begin
    por_d = por_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) por_q <= 1'b0;
    else        por_q <= por_d;
  end
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int HOLD_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  output logic done
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = active & tick;
  assign done   = cnt_en & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!active)                  cnt_d = '0;
    else if (cnt_en && !done)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_entry_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (cnt_q == '0));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_now,
  input  logic       ot_trip,
  input  logic       oc_trip,
  input  logic       ss_low,
  input  logic       ss_top,
  input  logic       hold_done,
  output seq_state_t state_q,
  output logic       hold_active
);
  seq_state_t state_d;

  assign hold_active = (state_q == ST_HICCUP);

  always_comb begin
    state_d = state_q;
    if (!por_now) begin
      state_d = ST_OFF;
    end else if (ot_trip) begin
      state_d = ST_THERMAL;
    end else begin
      case (state_q)
        ST_OFF:     state_d = ST_CHARGE;
        ST_CHARGE: begin
          if (oc_trip)     state_d = ST_HICCUP;
          else if (ss_top) state_d = ST_RUN;
        end
        ST_RUN: begin
          if (oc_trip)     state_d = ST_HICCUP;
          else if (ss_low) state_d = ST_SHUT;
        end
        ST_HICCUP:  if (hold_done) state_d = ST_CHARGE;
        ST_THERMAL: state_d = ST_CHARGE;
        ST_SHUT:    if (!ss_low) state_d = ST_CHARGE;
        default:    state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assert_oc_enters_hiccup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_CHARGE || state_q == ST_RUN) && oc_trip && por_now && !ot_trip)
    |=> (state_q == ST_HICCUP));
  assert_hiccup_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HICCUP && por_now && !ot_trip && !hold_done)
    |=> (state_q == ST_HICCUP));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int HOLD_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_ok,
  input  logic en_ok,
  input  logic ss_low,
  input  logic ss_top,
  input  logic oc_trip,
  input  logic ot_trip,
  input  logic cyc_tick,
  output logic por_ok,
  output logic ss_charge,
  output logic drv_hiz,
  output logic hiccup_on
);
  logic       por_now;
  logic       hold_active;
  logic       hold_done;
  seq_state_t state_q;

  por_qualify u_por (
    .clk     (clk),
    .rst_n   (rst_n),
    .vcc_ok  (vcc_ok),
    .en_ok   (en_ok),
    .por_now (por_now),
    .por_q   (por_ok)
  );

  hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (hold_active),
    .tick   (cyc_tick),
    .done   (hold_done)
  );

  seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_now     (por_now),
    .ot_trip     (ot_trip),
    .oc_trip     (oc_trip),
    .ss_low      (ss_low),
    .ss_top      (ss_top),
    .hold_done   (hold_done),
    .state_q     (state_q),
    .hold_active (hold_active)
  );

  always_comb begin
    ss_charge = (state_q == ST_CHARGE) || (state_q == ST_RUN) || (state_q == ST_SHUT);
    drv_hiz   = !((state_q == ST_CHARGE) || (state_q == ST_RUN));
    hiccup_on = (state_q == ST_HICCUP);
  end

  assert_hiz_without_por_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |-> (drv_hiz && !ss_charge));
  assert_charge_needs_por_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ss_charge |-> por_ok);
  assert_thermal_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_ok && en_ok && ot_trip) |=> (drv_hiz && !ss_charge && !hiccup_on));
  assert_hiccup_discharged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hiccup_on |-> (!ss_charge && drv_hiz));
endmodule

// File: tb/pwr_seq_ctrl_test.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_test;
  localparam int HOLD = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_ok = 1'b0, en_ok = 1'b0, ss_low = 1'b0, ss_top = 1'b0;
  logic oc_trip = 1'b0, ot_trip = 1'b0, cyc_tick = 1'b0;
  logic por_ok, ss_charge, drv_hiz, hiccup_on;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  pwr_seq_ctrl #(.HOLD_CYC(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .en_ok(en_ok),
    .ss_low(ss_low), .ss_top(ss_top), .oc_trip(oc_trip), .ot_trip(ot_trip),
    .cyc_tick(cyc_tick), .por_ok(por_ok), .ss_charge(ss_charge),
    .drv_hiz(drv_hiz), .hiccup_on(hiccup_on)
  );

  // expected item: {por_ok, ss_charge, drv_hiz, hiccup_on}
  task automatic step(input logic chk, input logic [3:0] exp, input string tag);
    @(posedge clk);
    if (chk) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
  endtask

  task automatic drive(input logic v, input logic e, input logic sl, input logic st,
                       input logic oc, input logic ot, input logic tk);
    @(negedge clk);
    vcc_ok = v; en_ok = e; ss_low = sl; ss_top = st;
    oc_trip = oc; ot_trip = ot; cyc_tick = tk;
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      logic [3:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {por_ok, ss_charge, drv_hiz, hiccup_on};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual=%b expected=%b", t, a, e);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({por_ok, ss_charge, drv_hiz, hiccup_on} !== 4'b0010) begin
      errors++;
      $display("FAIL R1 in reset: actual=%b expected=0010", {por_ok, ss_charge, drv_hiz, hiccup_on});
    end
    @(negedge clk); rst_n = 1'b1;
    drive(0,0,0,0,0,0,0); step(1, 4'b0010, "R1 after release");
    drive(1,0,0,0,0,0,0); step(1, 4'b0010, "R2 supply only");
    drive(0,1,0,0,1,0,0); step(1, 4'b0010, "R2 enable only");
    drive(1,1,1,0,0,0,0); step(1, 4'b1100, "R3 start charge");
    drive(1,1,1,0,0,0,0); step(1, 4'b1100, "R4 low ignored before top");
    drive(1,1,0,1,0,0,0); step(1, 4'b1100, "R4 reach top");
    drive(1,1,1,0,0,0,0); step(1, 4'b1110, "R4 pulled low shuts");
    drive(1,1,1,0,1,0,0); step(1, 4'b1110, "R4 shut holds");
    drive(1,1,0,0,0,0,0); step(1, 4'b1100, "R4 resume");
    drive(1,1,0,0,1,0,0); step(1, 4'b1011, "R5 trip enters hiccup");
    // 4095 ticks interleaved with idle cycles; oc stays high (ignored)
    for (int i = 0; i < HOLD - 1; i++) begin
      drive(1,1,1,0,1,0,1); step(0, 4'b0000, "");
      drive(1,1,1,0,1,0,0); step(0, 4'b0000, "");
    end
    drive(1,1,1,0,1,0,0); step(1, 4'b1011, "R6 held one tick before end");
    drive(1,1,1,0,0,0,1); step(1, 4'b1100, "R6 release on last tick");
    drive(1,1,1,0,1,0,0); step(1, 4'b1011, "R6 repeat hiccup");
    drive(1,1,1,0,1,0,1); step(1, 4'b1011, "R5 trip ignored in hiccup");
    drive(1,1,1,0,1,1,0); step(1, 4'b1010, "R7 thermal over hiccup");
    drive(1,1,1,0,1,1,0); step(1, 4'b1010, "R7 thermal holds");
    drive(1,1,1,0,0,0,0); step(1, 4'b1100, "R7 auto restart");
    drive(1,1,0,0,0,1,0); step(1, 4'b1010, "R7 thermal from charge");
    drive(1,0,0,0,0,1,0); step(1, 4'b0010, "R8 power loss over thermal");
    drive(1,1,0,0,0,0,0); step(1, 4'b1100, "R2 requalify");
    drive(0,1,0,0,0,0,0); step(1, 4'b0010, "R2 supply loss");
    drive(0,0,0,0,0,0,0); step(1, 4'b0010, "R2 stays off");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule